// File: doc/BRIEF.md
# Long Descriptor Type and Offset Decoder

This block decodes one 64-bit long-format translation descriptor. Each descriptor comes with the lookup level it was fetched at and the granule size in force. The block sorts the entry into one of four kinds: invalid, block, table or page.

- For a block or a page, it reports how many low address bits form the offset inside the mapped region. It then builds the output physical address by keeping the descriptor's address bits above that offset and filling the bits below it from the virtual address.
- For a table, it reports the base of the next-level table. This is the descriptor's address field with every bit below the granule exponent cleared.

A page-walk engine places the block between its descriptor fetch and its next step. Each accepted input yields one registered result on the next clock. The block does not check attributes or permissions, and it does not sequence the walk.

Top module: `ldesc_decode`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0, `out_kind` is 0, `out_ofs` is 0 and `out_addr` is 0.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge, so every result appears exactly one cycle after its input.
- R3: A descriptor with bit 0 equal to 0 decodes as invalid. Invalid is kind code 0, and it comes with `out_ofs` = 0 and `out_addr` = 0.
- R4: Descriptor bits [1:0] = 11 at level 3 decode as a page (kind code 3). Its `out_ofs` is 12, 14 or 16 for granule code 0, 1 or 2.
- R5: Descriptor bits [1:0] = 11 at levels 0, 1 and 2 decode as a table (kind code 2). It comes with `out_ofs` = 0, and `out_addr` equals descriptor bits [47:0] with bits below the granule exponent (12, 14 or 16) cleared.
- R6: With granule code 0 (4 KB), descriptor bits [1:0] = 01 decode as a block (kind code 1) at levels 1 and 2. The same bits decode as invalid at levels 0 and 3.
- R7: With granule code 1 (16 KB) or 2 (64 KB), descriptor bits [1:0] = 01 decode as a block only at level 2. They decode as invalid at every other level.
- R8: The block offset width is set by granule and level:
  - granule 0 at level 1: 30;
  - granule 0 at level 2: 21;
  - granule 1: 25;
  - granule 2: 29.
- R9: For a block or a page, `out_addr` is descriptor bits [47:`out_ofs`] joined with `in_va` bits [`out_ofs`-1:0].
- R10: Granule code 3 is reserved and decodes exactly as granule code 0.
- R11: A cycle with `in_valid` low leaves `out_kind`, `out_ofs` and `out_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor and context are valid this cycle |
| in_desc | input | 64 | Fetched descriptor word |
| in_level | input | 2 | Lookup level, 0 to 3 |
| in_gran | input | 2 | Granule code: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = reserved |
| in_va | input | PA_W (48) | Low virtual-address bits used for the offset |
| out_valid | output | 1 | Result valid |
| out_kind | output | 2 | 0 invalid, 1 block, 2 table, 3 page |
| out_ofs | output | OFS_W (6) | Offset width of a block or page, else 0 |
| out_addr | output | PA_W (48) | Physical address, or next table base |

## Verification
The bench builds the block with its default 48-bit address width. Because the decode depends only on descriptor bits [1:0], the level and the granule code, 64 control combinations cover the decode completely. The bench runs all of them, with several pseudo-random address patterns each. This reaches:
- every legal and illegal block case;
- all four offset widths at both ends of the merge mask;
- the reserved granule code.

Separate sequences cover reset and output hold while idle.

// File: rtl/ldesc_pkg.sv
package ldesc_pkg;
  typedef enum logic [1:0] {
    K_INVALID = 2'd0,
    K_BLOCK   = 2'd1,
    K_TABLE   = 2'd2,
    K_PAGE    = 2'd3
  } ent_kind_t;

  typedef enum logic [1:0] {
    G_4K   = 2'd0,
    G_16K  = 2'd1,
    G_64K  = 2'd2,
    G_RSVD = 2'd3
  } gran_t;

  localparam int EXP_4K      = 12;
  localparam int EXP_STEP    = 2;
  localparam int BLK_4K_L1   = 30;
  localparam int BLK_4K_L2   = 21;
  localparam int BLK_16K     = 25;
  localparam int BLK_64K     = 29;
endpackage

// File: rtl/ldesc_classify.sv
module ldesc_classify
  import ldesc_pkg::*;
(
  input  logic [1:0] tag,
  input  logic [1:0] level,
  input  gran_t      gran,
  output ent_kind_t  kind
);
  logic blk_ok;

  always_comb begin
    if (gran == G_4K) blk_ok = (level == 2'd1) || (level == 2'd2);
    else              blk_ok = (level == 2'd2);
  end

  always_comb begin
    kind = K_INVALID;
    if (tag[0]) begin
      if (tag[1]) kind = (level == 2'd3) ? K_PAGE : K_TABLE;
      else        kind = blk_ok ? K_BLOCK : K_INVALID;
    end
  end
endmodule

// File: rtl/ldesc_offset.sv
module ldesc_offset
  import ldesc_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  ent_kind_t          kind,
  input  logic [1:0]         level,
  input  gran_t              gran,
  output logic [OFS_W-1:0]   ofs,
  output logic [OFS_W-1:0]   cut,
  output logic               use_va
);
  logic [OFS_W-1:0] gexp;
  logic [OFS_W-1:0] bsize;

  always_comb begin
    gexp = OFS_W'(EXP_4K + EXP_STEP * int'(gran));
    case (gran)
      G_16K:   bsize = OFS_W'(BLK_16K);
      G_64K:   bsize = OFS_W'(BLK_64K);
      default: bsize = (level == 2'd1) ? OFS_W'(BLK_4K_L1) : OFS_W'(BLK_4K_L2);
    endcase
  end

  always_comb begin
    ofs    = '0;
    cut    = '0;
    use_va = 1'b0;
    case (kind)
      K_BLOCK: begin ofs = bsize; cut = bsize; use_va = 1'b1; end
      K_PAGE:  begin ofs = gexp;  cut = gexp;  use_va = 1'b1; end
      K_TABLE: begin cut = gexp; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ldesc_merge.sv
module ldesc_merge #(
  parameter int PA_W  = 48,
  parameter int OFS_W = 6
) (
  input  logic               en,
  input  logic [PA_W-1:0]    oa,
  input  logic [PA_W-1:0]    va,
  input  logic [OFS_W-1:0]   cut,
  input  logic               use_va,
  output logic [PA_W-1:0]    addr
);
  logic [PA_W-1:0] lowmask;

  for (genvar i = 0; i < PA_W; i++) begin : g_mask
    assign lowmask[i] = (OFS_W'(i) < cut);
  end

  always_comb begin
    if (!en)         addr = '0;
    else if (use_va) addr = (oa & ~lowmask) | (va & lowmask);
    else             addr = oa & ~lowmask;
  end
endmodule

// File: rtl/ldesc_decode.sv
module ldesc_decode
  import ldesc_pkg::*;
#(
  parameter int DESC_W = 64,
  parameter int PA_W   = 48,
  localparam int OFS_W = $clog2(PA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DESC_W-1:0] in_desc,
  input  logic [1:0]        in_level,
  input  logic [1:0]        in_gran,
  input  logic [PA_W-1:0]   in_va,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [OFS_W-1:0]  out_ofs,
  output logic [PA_W-1:0]   out_addr
);
  gran_t            gran_n;
  ent_kind_t        kind_d;
  logic [OFS_W-1:0] ofs_d;
  logic [OFS_W-1:0] cut_d;
  logic             use_va_d;
  logic [PA_W-1:0]  addr_d;

  // Reserved granule code falls back to the 4 KB behaviour.
  assign gran_n = (gran_t'(in_gran) == G_RSVD) ? G_4K : gran_t'(in_gran);

  ldesc_classify u_cls (
    .tag   (in_desc[1:0]),
    .level (in_level),
    .gran  (gran_n),
    .kind  (kind_d)
  );

  ldesc_offset #(.OFS_W(OFS_W)) u_ofs (
    .kind   (kind_d),
    .level  (in_level),
    .gran   (gran_n),
    .ofs    (ofs_d),
    .cut    (cut_d),
    .use_va (use_va_d)
  );

  ldesc_merge #(.PA_W(PA_W), .OFS_W(OFS_W)) u_mrg (
    .en     (kind_d != K_INVALID),
    .oa     (in_desc[PA_W-1:0]),
    .va     (in_va),
    .cut    (cut_d),
    .use_va (use_va_d),
    .addr   (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= K_INVALID;
      out_ofs   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind <= kind_d;
        out_ofs  <= ofs_d;
        out_addr <= addr_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_kind) && $stable(out_ofs) && $stable(out_addr))); // R11
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_kind == 2'd0) |-> (out_ofs == '0 && out_addr == '0)); // R3
  AST_PAGE_AT_L3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_desc[1:0] == 2'b11 && in_level == 2'd3) |=> (out_kind == 2'd3)); // R4
  AST_TABLE_NO_OFS: assert property (@(posedge clk) disable iff (rst)
    (out_kind == 2'd2) |-> (out_ofs == '0)); // R5
  AST_BLOCK_SIZES: assert property (@(posedge clk) disable iff (rst)
    (out_kind == 2'd1) |-> (out_ofs == 6'd21 || out_ofs == 6'd25 ||
                            out_ofs == 6'd29 || out_ofs == 6'd30)); // R8
endmodule

// File: tb/test_ldesc_decode.sv
module test_ldesc_decode;
  localparam int PA_W = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_desc = '0;
  logic [1:0]  in_level = '0;
  logic [1:0]  in_gran = '0;
  logic [47:0] in_va = '0;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [5:0]  out_ofs;
  logic [47:0] out_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  ldesc_decode i_ldesc_decode (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_desc(in_desc),
    .in_level(in_level), .in_gran(in_gran), .in_va(in_va),
    .out_valid(out_valid), .out_kind(out_kind), .out_ofs(out_ofs),
    .out_addr(out_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  logic [1:0]  last_kind;
  logic [5:0]  last_ofs;
  logic [47:0] last_addr;

  task automatic run_vec(input logic [63:0] d, input logic [1:0] lv,
                         input logic [1:0] g, input logic [47:0] va);
    int ge, kind, ofs, cut;
    logic [47:0] mask, ea;
    string tk, ta;
    ge = (g == 2'd3) ? 0 : int'(g);
    kind = 0; ofs = 0; cut = 0;
    if (d[0]) begin
      if (d[1]) kind = (lv == 2'd3) ? 3 : 2;
      else if (ge == 0) kind = (lv == 2'd1 || lv == 2'd2) ? 1 : 0;
      else kind = (lv == 2'd2) ? 1 : 0;
    end
    if (kind == 1) ofs = (ge == 1) ? 25 : (ge == 2) ? 29 : (lv == 2'd1) ? 30 : 21;
    if (kind == 3) ofs = 12 + 2 * ge;
    cut = (kind == 2) ? 12 + 2 * ge : ofs;
    mask = (48'h1 << cut) - 48'h1;
    if (kind == 0)      ea = '0;
    else if (kind == 2) ea = d[47:0] & ~mask;
    else                ea = (d[47:0] & ~mask) | (va & mask);

    if (g == 2'd3)                tk = "R10";
    else if (d[1:0] == 2'b01)     tk = (ge == 0) ? "R6" : "R7";
    else if (kind == 3)           tk = "R4";
    else if (kind == 2)           tk = "R5";
    else                          tk = "R3";
    ta = (kind == 1 || kind == 3) ? "R9" : (kind == 2) ? "R5" : "R3";

    @(negedge clk);
    in_valid = 1'b1; in_desc = d; in_level = lv; in_gran = g; in_va = va;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "out_valid", 64'(out_valid), 64'd1);
    chk(tk, "kind", 64'(out_kind), 64'(kind));
    chk((kind == 1) ? "R8" : tk, "ofs", 64'(out_ofs), 64'(ofs));
    chk(ta, "addr", 64'(out_addr), 64'(ea));
    last_kind = 2'(kind); last_ofs = 6'(ofs); last_addr = ea;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset held, even with in_valid high
    chk("R1", "valid in reset", 64'(out_valid), 64'd0);
    chk("R1", "kind in reset", 64'(out_kind), 64'd0);
    chk("R1", "ofs in reset", 64'(out_ofs), 64'd0);
    chk("R1", "addr in reset", 64'(out_addr), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", 64'(out_valid), 64'd0);
    chk("R1", "addr after reset", 64'(out_addr), 64'd0);

    // Full sweep of tag x level x granule with pseudo-random address fields
    for (int rep = 0; rep < 4; rep++) begin
      for (int t = 0; t < 4; t++) begin
        for (int lv = 0; lv < 4; lv++) begin
          for (int g = 0; g < 4; g++) begin
            logic [63:0] d;
            logic [47:0] va;
            d = nxt();
            va = nxt()[47:0];
            if (rep == 1) begin d = {62'h0, 2'b00} | 64'hFFFF_FFFF_FFFF_FFFC; va = '0; end
            if (rep == 2) begin d = 64'h0; va = '1; end
            d[1:0] = 2'(t);
            run_vec(d, 2'(lv), 2'(g), va);
          end
        end
      end
    end

    // R11: idle cycles with changing inputs must not disturb held outputs
    run_vec(64'h0000_1234_5678_9AB1, 2'd1, 2'd0, 48'hFFFF_FFFF_FFFF);
    in_desc = 64'hFFFF_FFFF_FFFF_FFFF; in_level = 2'd3; in_gran = 2'd2; in_va = '0;
    repeat (3) @(negedge clk);
    chk("R11", "held kind", 64'(out_kind), 64'(last_kind));
    chk("R11", "held ofs", 64'(out_ofs), 64'(last_ofs));
    chk("R11", "held addr", 64'(out_addr), 64'(last_addr));
    chk("R2", "valid idle", 64'(out_valid), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule